// File: doc/BRIEF.md
# Three-Wire Addressed Serial Control Port

This block is the slave side of a three-wire control link: an enable line, a serial clock and a data-in line, plus a data-out line that can only pull low. A host selects what a frame does by shifting an 8-bit address code while the enable is low. When the enable rises, that code is decoded into one of two write banks, a status read, or an ignored frame.

In a write frame, data bits are collected into a shift register. They are copied into the selected parallel control bank only when the enable falls. In a read frame, a 22-bit status word is captured at the enable rise and shifted out on the data-out line, one bit per serial clock period. The serial clock may rest high or low between frames.

All three serial lines are brought into a faster system clock domain through two-flop synchronizers, and their edges are detected there. The open-drain output is modelled as an enable that is high only while the line must be pulled low.

Top module: `ser3_ctrl_port`

## Requirements
- R1: Address bits are taken from di_i on each rising serial clock edge while ce_i is low. The last eight bits received are decoded when ce_i rises, and the first-sent bit counts as the leftmost bit of the code.
- R2: Code 1001_0100 selects bank A, code 0001_0100 selects bank B, and code 0101_0100 selects the status read.
- R3: In a write frame, di_i is sampled on each rising serial clock edge. The first data bit sent lands in bit 0 of the bank and the last in bit DATA_W-1.
- R4: A bank output changes only in the system cycle that follows the detected fall of ce_i, and only for the bank the frame addressed.
- R5: A write frame that carries a number of data bits other than DATA_W leaves both banks unchanged.
- R6: A frame with any other address code updates no bank and never asserts do_oe_o.
- R7: do_oe_o stays low throughout write frames and whenever ce_i is low.
- R8: The read word is sent in this order: stereo flag, signal-detect flag, count bits 19 down to 11, the lock flag in place of count bit 10, then count bits 9 down to 0. A 0 bit is sent as do_oe_o high and a 1 bit as do_oe_o low.
- R9: All status inputs are captured at the ce_i rise that starts a read frame. Later changes to them do not alter that frame.
- R10: The first read bit is presented when the frame starts. Each falling serial clock edge that follows a rising edge in the same frame advances to the next bit, so a clock resting either high or low gives the same bit stream.
- R11: Once all 22 read bits have been stepped past, do_oe_o stays low until the frame ends.
- R12: While rst_ni is low, both banks clear to zero and do_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial frame enable |
| cl_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data from host |
| stereo_i | input | 1 | Stereo indicator status bit |
| sigdet_i | input | 1 | Signal-detect indicator status bit |
| lock_i | input | 1 | Lock status bit, sent in place of count bit 10 |
| count_i | input | CNT_W | Counter result to be read back |
| bank_a_o | output | DATA_W | Control bank A |
| bank_b_o | output | DATA_W | Control bank B |
| do_oe_o | output | 1 | Pull-low enable of the open-drain data-out line |

## Verification
A wrong address decode or a bad bit count shows on the bank outputs a few system cycles after the enable falls: the wrong bank changes, or a short or long frame gets committed. A read pointer that is off by one shifts the whole returned word, so it shows on the very first bit the host samples. This is what separates a clock that rests high from one that rests low. A status value latched at the wrong moment shows as a word that follows inputs changed after the frame started.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_WR_A = 3'd1,
    M_WR_B = 3'd2,
    M_RD   = 3'd3,
    M_IGN  = 3'd4
  } mode_e;

  localparam logic [7:0] ADDR_WR_A = 8'b1001_0100;
  localparam logic [7:0] ADDR_WR_B = 8'b0001_0100;
  localparam logic [7:0] ADDR_RD   = 8'b0101_0100;

  function automatic mode_e decode_addr(input logic [7:0] a);
    case (a)
      ADDR_WR_A: decode_addr = M_WR_A;
      ADDR_WR_B: decode_addr = M_WR_B;
      ADDR_RD:   decode_addr = M_RD;
      default:   decode_addr = M_IGN;
    endcase
  endfunction
endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], raw_i[g]};
    end
    assign sync_o[g] = ff_q[1];
  end
endmodule

// File: rtl/ser3_rx.sv
module ser3_rx
  import ser3_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ce_rise_i,
  input  logic              ce_fall_i,
  input  logic              cl_rise_i,
  input  logic              di_i,
  output mode_e             mode_o,
  output logic              rd_start_o,
  output logic [DATA_W-1:0] bank_a_o,
  output logic [DATA_W-1:0] bank_b_o
);
  localparam int CNT_BITS = $clog2(DATA_W + 2);
  localparam logic [CNT_BITS-1:0] CNT_FULL = CNT_BITS'(DATA_W);
  localparam logic [CNT_BITS-1:0] CNT_SAT  = CNT_BITS'(DATA_W + 1);

  logic [7:0]          addr_q;
  logic [DATA_W-1:0]   shift_q;
  logic [CNT_BITS-1:0] cnt_q;
  mode_e               mode_q, mode_d;
  logic                wr_mode;

  assign mode_d     = decode_addr(addr_q);
  assign rd_start_o = ce_rise_i && (mode_d == M_RD);
  assign wr_mode    = (mode_q == M_WR_A) || (mode_q == M_WR_B);
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      shift_q  <= '0;
      cnt_q    <= '0;
      mode_q   <= M_IDLE;
      bank_a_o <= '0;
      bank_b_o <= '0;
    end else begin
      if (cl_rise_i && !ce_i) addr_q <= {addr_q[6:0], di_i};
      if (ce_rise_i) begin
        mode_q <= mode_d;
        cnt_q  <= '0;
      end else if (ce_fall_i) begin
        if (cnt_q == CNT_FULL && mode_q == M_WR_A) bank_a_o <= shift_q;
        if (cnt_q == CNT_FULL && mode_q == M_WR_B) bank_b_o <= shift_q;
        mode_q <= M_IDLE;
      end else if (cl_rise_i && ce_i && wr_mode) begin
        shift_q <= {di_i, shift_q[DATA_W-1:1]};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser3_tx.sv
module ser3_tx #(
  parameter int CNT_W      = 20,
  parameter int UNLOCK_POS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             cl_rise_i,
  input  logic             cl_fall_i,
  input  logic             stereo_i,
  input  logic             sigdet_i,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             oe_o
);
  localparam int FRAME_W = CNT_W + 2;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   merged;
  logic [FRAME_W-1:0] frame_q;
  logic [LEFT_W-1:0]  left_q;
  logic               armed_q;

  always_comb begin
    merged             = count_i;
    merged[UNLOCK_POS] = lock_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      left_q  <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      frame_q <= {stereo_i, sigdet_i, merged};
      left_q  <= LEFT_W'(FRAME_W);
      armed_q <= 1'b0;
    end else if (active_i) begin
      if (cl_rise_i) armed_q <= 1'b1;
      // a fall with no prior rise is the start of an idle-high clock
      if (cl_fall_i && armed_q && left_q != '0) begin
        frame_q <= frame_q << 1;
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign oe_o = active_i && (left_q != '0) && !frame_q[FRAME_W-1];
endmodule

// File: rtl/ser3_ctrl_port.sv
module ser3_ctrl_port
  import ser3_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int CNT_W      = 20,
  parameter int UNLOCK_POS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cl_i,
  input  logic              di_i,
  input  logic              stereo_i,
  input  logic              sigdet_i,
  input  logic              lock_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] bank_a_o,
  output logic [DATA_W-1:0] bank_b_o,
  output logic              do_oe_o
);
  logic [2:0] sync;
  logic       ce_s, cl_s, di_s;
  logic       ce_prev_q, cl_prev_q;
  logic       ce_rise, ce_fall, cl_rise, cl_fall;
  logic       rd_start, rd_active;
  mode_e      mode;

  ser3_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({di_i, cl_i, ce_i}),
    .sync_o(sync)
  );
  assign {di_s, cl_s, ce_s} = sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q <= 1'b0;
      cl_prev_q <= 1'b0;
    end else begin
      ce_prev_q <= ce_s;
      cl_prev_q <= cl_s;
    end
  end

  assign ce_rise = ce_s && !ce_prev_q;
  assign ce_fall = !ce_s && ce_prev_q;
  assign cl_rise = cl_s && !cl_prev_q;
  assign cl_fall = !cl_s && cl_prev_q;

  ser3_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_s),
    .ce_rise_i (ce_rise),
    .ce_fall_i (ce_fall),
    .cl_rise_i (cl_rise),
    .di_i      (di_s),
    .mode_o    (mode),
    .rd_start_o(rd_start),
    .bank_a_o  (bank_a_o),
    .bank_b_o  (bank_b_o)
  );

  assign rd_active = ce_s && (mode == M_RD);

  ser3_tx #(.CNT_W(CNT_W), .UNLOCK_POS(UNLOCK_POS)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rd_start),
    .active_i (rd_active),
    .cl_rise_i(cl_rise),
    .cl_fall_i(cl_fall),
    .stereo_i (stereo_i),
    .sigdet_i (sigdet_i),
    .lock_i   (lock_i),
    .count_i  (count_i),
    .oe_o     (do_oe_o)
  );
endmodule

// File: rtl/ser3_ctrl_port_chk.sv
module ser3_ctrl_port_chk
  import ser3_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              ce_fall_i,
  input mode_e             mode_i,
  input logic [DATA_W-1:0] bank_a_i,
  input logic [DATA_W-1:0] bank_b_i,
  input logic              do_oe_i
);
  AST_BANK_A_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_fall_i |=> $stable(bank_a_i)); // R4
  AST_BANK_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_fall_i |=> $stable(bank_b_i)); // R4
  AST_WRITE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_WR_A || mode_i == M_WR_B) |-> !do_oe_i); // R7
  AST_IGNORED_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_IGN) |-> !do_oe_i); // R6
  AST_CE_LOW_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> !do_oe_i); // R7
  AST_FRAME_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_fall_i |=> (mode_i == M_IDLE)); // R1
endmodule

bind ser3_ctrl_port ser3_ctrl_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_i     (ce_s),
  .ce_fall_i(ce_fall),
  .mode_i   (mode),
  .bank_a_i (bank_a_o),
  .bank_b_i (bank_b_o),
  .do_oe_i  (do_oe_o)
);

// File: tb/ser3_ctrl_port_tb.sv
module ser3_ctrl_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;
  localparam int DW = 24;
  localparam int CW = 20;
  localparam int NV = 6;
  // {idle_hi, addr, nbits, data, exp_a, exp_b}
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 8'b1001_0100, 6'd24, 24'hA5C3F0, 24'hA5C3F0, 24'h000000},
    {1'b1, 8'b0001_0100, 6'd24, 24'h123456, 24'hA5C3F0, 24'h123456},
    {1'b0, 8'b1111_1111, 6'd24, 24'hFFFFFF, 24'hA5C3F0, 24'h123456},
    {1'b1, 8'b1001_0100, 6'd23, 24'h000001, 24'hA5C3F0, 24'h123456},
    {1'b0, 8'b0001_0100, 6'd24, 24'hFEDCBA, 24'hA5C3F0, 24'hFEDCBA},
    {1'b1, 8'b1001_0100, 6'd24, 24'h800001, 24'h800001, 24'hFEDCBA}
  };

  logic clk = 0, rst_n = 0;
  logic ce = 0, cl = 0, di = 0;
  logic stereo = 0, sigdet = 0, lock = 0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] bank_a, bank_b;
  logic do_oe;
  int n_run = 0, n_fail = 0;
  logic mon_en = 0, oe_seen = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser3_ctrl_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .stereo_i(stereo), .sigdet_i(sigdet), .lock_i(lock), .count_i(count),
    .bank_a_o(bank_a), .bank_b_o(bank_b), .do_oe_o(do_oe)
  );

  always @(negedge clk) if (mon_en && do_oe) oe_seen <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic send_bit(input logic idle_hi, input logic b);
    if (idle_hi) begin
      cl = 0; di = b; wait_h(); cl = 1; wait_h();
    end else begin
      di = b; wait_h(); cl = 1; wait_h(); cl = 0; wait_h();
    end
  endtask

  task automatic send_addr(input logic idle_hi, input logic [7:0] a);
    cl = idle_hi; ce = 0; wait_h();
    for (int i = 7; i >= 0; i--) send_bit(idle_hi, a[i]);
    wait_h(); ce = 1; wait_h();
  endtask

  task automatic wr_frame(input logic idle_hi, input logic [7:0] a,
                          input logic [DW-1:0] d, input int nb);
    send_addr(idle_hi, a);
    for (int i = 0; i < nb; i++) send_bit(idle_hi, d[i]);
    wait_h(); ce = 0; repeat (8) @(negedge clk);
  endtask

  task automatic rd_frame(input logic idle_hi, output logic [21:0] got, output logic rel);
    send_addr(idle_hi, 8'b0101_0100);
    // scramble status after capture (R9)
    stereo = ~stereo; sigdet = ~sigdet; lock = ~lock; count = ~count;
    for (int k = 0; k < 22; k++) begin
      if (idle_hi) begin
        cl = 0; wait_h(); got[21-k] = ~do_oe; cl = 1; wait_h();
      end else begin
        got[21-k] = ~do_oe; wait_h(); cl = 1; wait_h(); cl = 0; wait_h();
      end
    end
    if (idle_hi) begin cl = 0; wait_h(); cl = 1; wait_h(); end
    else begin cl = 1; wait_h(); cl = 0; wait_h(); end
    rel = ~do_oe;
    ce = 0; repeat (8) @(negedge clk);
  endtask

  function automatic logic [21:0] exp_word(logic s, logic d, logic l, logic [CW-1:0] c);
    return {s, d, c[19:11], l, c[9:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [21:0] got, exp;
    logic rel;
    repeat (3) @(negedge clk);
    chk("R12 bank_a reset", 32'(bank_a), 32'h0);
    chk("R12 bank_b reset", 32'(bank_b), 32'h0);
    chk("R12 oe reset", 32'(do_oe), 32'h0);
    rst_n = 1; repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 via table
    for (int v = 0; v < NV; v++) begin
      oe_seen = 0; mon_en = 1;
      wr_frame(VEC[v][86], VEC[v][85:78], VEC[v][71:48], int'(VEC[v][77:72]));
      mon_en = 0;
      chk($sformatf("R2/R3/R4/R5 vec%0d bank_a", v), 32'(bank_a), 32'(VEC[v][47:24]));
      chk($sformatf("R2/R3/R4/R6 vec%0d bank_b", v), 32'(bank_b), 32'(VEC[v][23:0]));
      chk($sformatf("R7/R6 vec%0d oe released", v), 32'(oe_seen), 32'h0);
    end

    // R8 R9 R10 R11, clock resting low
    stereo = 1; sigdet = 0; lock = 1; count = 20'hA53C7;
    exp = exp_word(1, 0, 1, 20'hA53C7);
    rd_frame(1'b0, got, rel);
    chk("R8/R9/R10 read idle-low", 32'(got), 32'(exp));
    chk("R11 release idle-low", 32'(rel), 32'h1);

    // clock resting high
    stereo = 0; sigdet = 1; lock = 1; count = 20'h0F0F0;
    exp = exp_word(0, 1, 1, 20'h0F0F0);
    rd_frame(1'b1, got, rel);
    chk("R8/R9/R10 read idle-high", 32'(got), 32'(exp));
    chk("R11 release idle-high", 32'(rel), 32'h1);

    // read must not disturb banks
    chk("R4 bank_a after read", 32'(bank_a), 32'h800001);
    chk("R4 bank_b after read", 32'(bank_b), 32'hFEDCBA);

    // R12 reset mid-run
    rst_n = 0; repeat (2) @(negedge clk);
    chk("R12 bank_a re-reset", 32'(bank_a), 32'h0);
    chk("R12 bank_b re-reset", 32'(bank_b), 32'h0);
    rst_n = 1; repeat (4) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule